// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI master that works through a list of up to sixteen prepared transfers without a processor in the loop. Before the run, the host loads a command byte and a transmit word for each slot, picks a first and a last slot, sets the serial clock divider and writes a start bit. The controller then takes the slots in ascending order. For each slot it drives the four chip-select lines from the command byte, shifts the transmit word out on MOSI and stores the word seen on MISO in the receive slot with the same index.

When the last slot has been stored, the controller raises a completion flag and goes idle. The flag can also drive an interrupt line. The host can read the index of the most recently stored slot at any time. If another master pulls the slave-select input low, the controller records a mode fault and abandons the run.

The host port is a single-cycle write port plus a combinational read port. Address bits [5:4] pick the area: 0 is command bytes, 1 is transmit words, 2 is receive words (read only) and 3 is registers. Bits [3:0] give the slot index or the register offset.

Top module: `spi_queue_master`

## Requirements
- R1: After reset the status register (address 0x33) reads 0, the chip selects read 4'hF, and SCK and the interrupt are low.
- R2: Start is requested by writing address 0x30 with end slot in bits [7:4] and first slot in bits [3:0], then writing bit 0 = 1 at address 0x32. The controller then sends the slots from first to end in order. Each slot sends the word written at 0x10+slot MSB first, using command byte (address 0x00+slot) bit 6 to pick the length: 1 means 16 bits, 0 means the low 8 bits.
- R3: MISO is captured at each SCK rising edge. The captured word goes into the receive slot at 0x20+slot. An 8-bit transfer stores its value in bits [7:0] with bits [15:8] zero. Receive slots outside the executed range keep their contents.
- R4: SCK idles low. One SCK period is 2×D system clocks, where D is the value at address 0x31 and D = 0 acts as 1. MOSI does not change while SCK is high.
- R5: During a slot's transfer the chip-select outputs equal bits [3:0] of its command byte. Whenever the controller is idle they are 4'hF.
- R6: If command bit 7 is 1, the chip selects go straight from that slot's value to the next slot's value. If it is 0, they return to 4'hF for D clocks before the next slot. After the last slot they always return to 4'hF.
- R7: Status bits [7:4] hold the index of the last slot stored. This field changes only in the cycle after a receive-slot write, and it equals the end slot once the run completes.
- R8: When the end slot is stored, status bit 0 (done) sets and status bit 2 (busy) clears in the same cycle. Writing 0x33 with bit 0 = 1 clears done.
- R9: The interrupt output equals done AND the enable bit (address 0x32 bit 1).
- R10: A start written while a run is in progress is dropped. No second run follows.
- R11: A low slave-select input sets status bit 1 (mode fault). A run in progress stops on the next clock with the chip selects at 4'hF, and done is not set. Writing 0x33 with bit 1 = 1 clears the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host write address |
| host_wdata | input | 16 | Host write data |
| host_rd_addr | input | 6 | Host read address |
| host_rdata | output | 16 | Host read data, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Peripheral chip-select levels |
| ss_n | input | 1 | Slave-select input; low signals a mode fault |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps every first/end slot pair with the first slot not above the end slot. It varies the divider, including zero, and changes the per-slot lengths and hold bits from run to run.

- An off-by-one in the slot walk would show up as a wrong bit count on MOSI or as a disturbed receive slot outside the range.
- A wrong 8-bit alignment would put received data in the upper byte.
- A broken hold bit would change how many times the chip selects return to idle during a run.

Separate runs target three further faults:
- a restart from a start written mid-run, which would show as extra SCK edges afterwards;
- an abort that leaves chip selects driven or sets done;
- a completed-slot pointer that never reaches the end slot.

// File: rtl/spiq_pkg.sv
// Package: shared types and host address map for the queued SPI master.
// Assumes a 6-bit host address: [5:4] area, [3:0] slot or register offset.
package spiq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_RUN,
        SQ_WB,
        SQ_GAP
    } seq_state_e;

    localparam logic [1:0] AREA_CMD = 2'd0;
    localparam logic [1:0] AREA_TX  = 2'd1;
    localparam logic [1:0] AREA_RX  = 2'd2;
    localparam logic [1:0] AREA_REG = 2'd3;

    localparam logic [3:0] REG_QPTR = 4'd0;
    localparam logic [3:0] REG_DIV  = 4'd1;
    localparam logic [3:0] REG_CTRL = 4'd2;
    localparam logic [3:0] REG_STAT = 4'd3;

    localparam int unsigned CMD_CONT_BIT = 7;
    localparam int unsigned CMD_LEN_BIT  = 6;

endpackage

// File: rtl/spiq_ram.sv
// Module: per-slot storage holding command bytes, transmit words and receive words.
// The host writes command and transmit slots; only the engine writes receive slots.
// The engine-side read is combinational and indexed by the active slot.
module spiq_ram #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              tx_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  host_rd_idx,
    output logic [7:0]        host_cmd,
    output logic [WORD_W-1:0] host_tx,
    output logic [WORD_W-1:0] host_rx,
    input  logic [IDX_W-1:0]  eng_idx,
    output logic [3:0]        eng_pcs,
    output logic              eng_cont,
    output logic              eng_len_full,
    output logic [WORD_W-1:0] eng_tx,
    input  logic              rx_we,
    input  logic [WORD_W-1:0] rx_wdata
);
    import spiq_pkg::*;

    logic [7:0]        cmd_mem [DEPTH];
    logic [WORD_W-1:0] tx_mem  [DEPTH];
    logic [WORD_W-1:0] rx_mem  [DEPTH];

    // Store host command/transmit writes and engine receive write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cmd_mem[i] <= '0;
                tx_mem[i]  <= '0;
                rx_mem[i]  <= '0;
            end
        end else begin
            if (cmd_we) cmd_mem[host_idx] <= host_wdata[7:0];
            if (tx_we)  tx_mem[host_idx]  <= host_wdata;
            if (rx_we)  rx_mem[eng_idx]   <= rx_wdata;
        end
    end

    // Provide combinational host and engine read views.
    always_comb begin
        host_cmd     = cmd_mem[host_rd_idx];
        host_tx      = tx_mem[host_rd_idx];
        host_rx      = rx_mem[host_rd_idx];
        eng_pcs      = cmd_mem[eng_idx][3:0];
        eng_cont     = cmd_mem[eng_idx][CMD_CONT_BIT];
        eng_len_full = cmd_mem[eng_idx][CMD_LEN_BIT];
        eng_tx       = tx_mem[eng_idx];
    end
endmodule

// File: rtl/spiq_shifter.sv
// Module: mode-0 serial engine. SCK idles low and MOSI is MSB first.
// MOSI moves on the falling edge and MISO is sampled on the rising edge.
// Each SCK half period lasts max(div,1) clocks. A short transfer is WORD_W/2 bits.
// Assumes start arrives only while idle; abort wins over everything.
module spiq_shifter #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DIV_W  = 8,
    localparam int unsigned HALF  = WORD_W / 2,
    localparam int unsigned CNT_W = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              len_full,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              xfer_done,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] sh_tx;
    logic [WORD_W-1:0] sh_rx;
    logic [CNT_W-1:0]  bits_left;
    logic [DIV_W-1:0]  hcnt;
    logic [DIV_W-1:0]  lim;
    logic              sck_q;
    logic              busy_q;
    logic              half_end;

    // Derive the half-period limit; zero behaves as one.
    always_comb begin
        lim      = (div == '0) ? DIV_W'(1) : div;
        half_end = busy_q && (hcnt == lim - DIV_W'(1));
    end

    // Run the bit timing, shifting and sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tx     <= '0;
            sh_rx     <= '0;
            bits_left <= '0;
            hcnt      <= '0;
            sck_q     <= 1'b0;
            busy_q    <= 1'b0;
        end else if (abort) begin
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            hcnt   <= '0;
        end else if (start) begin
            busy_q    <= 1'b1;
            sck_q     <= 1'b0;
            hcnt      <= '0;
            sh_rx     <= '0;
            sh_tx     <= len_full ? tx_word : {tx_word[HALF-1:0], {HALF{1'b0}}};
            bits_left <= len_full ? CNT_W'(WORD_W) : CNT_W'(HALF);
        end else if (busy_q) begin
            if (half_end) begin
                hcnt <= '0;
                if (!sck_q) begin
                    sck_q     <= 1'b1;
                    sh_rx     <= {sh_rx[WORD_W-2:0], miso};
                    bits_left <= bits_left - CNT_W'(1);
                end else begin
                    sck_q <= 1'b0;
                    if (bits_left == '0) busy_q <= 1'b0;
                    else                 sh_tx  <= {sh_tx[WORD_W-2:0], 1'b0};
                end
            end else begin
                hcnt <= hcnt + DIV_W'(1);
            end
        end
    end

    // Pulse completion after the last falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_done <= 1'b0;
        else        xfer_done <= !abort && half_end && sck_q && (bits_left == '0);
    end

    assign sck     = sck_q;
    assign mosi    = sh_tx[WORD_W-1];
    assign rx_word = sh_rx;
endmodule

// File: rtl/spiq_sequencer.sv
// Module: walks the slots from the latched first pointer to the end pointer.
// For each slot it launches a transfer, writes the result back and drives the chip selects.
// Assumes the engine read of slot data is combinational at index idx.
module spiq_sequencer #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic [IDX_W-1:0] new_qp,
    input  logic [IDX_W-1:0] end_qp,
    input  logic [DIV_W-1:0] div,
    input  logic [3:0]       cmd_pcs,
    input  logic             cmd_cont,
    input  logic             xfer_done,
    output logic [IDX_W-1:0] eng_idx,
    output logic             xfer_start,
    output logic             rx_we,
    output logic [IDX_W-1:0] cpt_qp,
    output logic [3:0]       pcs,
    output logic             busy,
    output logic             queue_done
);
    import spiq_pkg::*;

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] end_q;
    logic             cont_q;
    logic [DIV_W-1:0] gap_cnt;
    logic [DIV_W-1:0] lim;
    logic             last_slot;

    // Decode per-state strobes.
    always_comb begin
        lim        = (div == '0) ? DIV_W'(1) : div;
        last_slot  = (idx == end_q);
        xfer_start = (state == SQ_LOAD) && !abort;
        rx_we      = (state == SQ_WB) && !abort;
        queue_done = rx_we && last_slot;
        busy       = (state != SQ_IDLE);
        eng_idx    = idx;
    end

    // Advance the slot walk and drive the chip selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            end_q   <= '0;
            cont_q  <= 1'b0;
            gap_cnt <= '0;
            cpt_qp  <= '0;
            pcs     <= 4'hF;
        end else if (abort) begin
            state <= SQ_IDLE;
            pcs   <= 4'hF;
        end else begin
            unique case (state)
                SQ_IDLE: if (go) begin
                    idx   <= new_qp;
                    end_q <= end_qp;
                    state <= SQ_LOAD;
                end
                SQ_LOAD: begin
                    pcs    <= cmd_pcs;
                    cont_q <= cmd_cont;
                    state  <= SQ_RUN;
                end
                SQ_RUN: if (xfer_done) state <= SQ_WB;
                SQ_WB: begin
                    cpt_qp <= idx;
                    if (last_slot) begin
                        pcs   <= 4'hF;
                        state <= SQ_IDLE;
                    end else begin
                        idx <= idx + IDX_W'(1);
                        if (cont_q) begin
                            state <= SQ_LOAD;
                        end else begin
                            pcs     <= 4'hF;
                            gap_cnt <= '0;
                            state   <= SQ_GAP;
                        end
                    end
                end
                SQ_GAP: begin
                    if (gap_cnt == lim - DIV_W'(1)) state <= SQ_LOAD;
                    else gap_cnt <= gap_cnt + DIV_W'(1);
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_queue_master.sv
// Module: top of the queued SPI master. It holds the host registers and address decode,
// plus the done/fault flags.
// Assumes ss_n and miso are already synchronous to clk. DEPTH must be at most 16.
module spi_queue_master #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DIV_W  = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [5:0]  host_addr,
    input  logic [15:0] host_wdata,
    input  logic [5:0]  host_rd_addr,
    output logic [15:0] host_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [3:0]  pcs,
    input  logic        ss_n,
    output logic        irq
);
    import spiq_pkg::*;

    logic [IDX_W-1:0]  new_qp, end_qp, cpt_qp, eng_idx;
    logic [DIV_W-1:0]  div_q;
    logic              irq_en_q, done_f, fault_f;
    logic              wr_reg, go, abort;
    logic              cmd_we, tx_we, rx_we;
    logic [7:0]        host_cmd;
    logic [WORD_W-1:0] host_tx, host_rx, eng_tx, rx_word;
    logic [3:0]        eng_pcs;
    logic              eng_cont, eng_len_full;
    logic              xfer_start, xfer_done, seq_busy, queue_done;

    // Decode host writes into areas and strobes.
    always_comb begin
        wr_reg = host_we && (host_addr[5:4] == AREA_REG);
        cmd_we = host_we && (host_addr[5:4] == AREA_CMD);
        tx_we  = host_we && (host_addr[5:4] == AREA_TX);
        go     = wr_reg && (host_addr[3:0] == REG_CTRL) && host_wdata[0];
        abort  = !ss_n;
    end

    // Hold the pointer, divider and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_qp   <= '0;
            end_qp   <= '0;
            div_q    <= '0;
            irq_en_q <= 1'b0;
        end else if (wr_reg) begin
            if (host_addr[3:0] == REG_QPTR) begin
                new_qp <= host_wdata[0 +: IDX_W];
                end_qp <= host_wdata[4 +: IDX_W];
            end
            if (host_addr[3:0] == REG_DIV)  div_q    <= host_wdata[DIV_W-1:0];
            if (host_addr[3:0] == REG_CTRL) irq_en_q <= host_wdata[1];
        end
    end

    // Set or clear the completion and mode-fault flags; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f  <= 1'b0;
            fault_f <= 1'b0;
        end else begin
            if (queue_done) done_f <= 1'b1;
            else if (wr_reg && host_addr[3:0] == REG_STAT && host_wdata[0]) done_f <= 1'b0;
            if (abort) fault_f <= 1'b1;
            else if (wr_reg && host_addr[3:0] == REG_STAT && host_wdata[1]) fault_f <= 1'b0;
        end
    end

    // Mux the host read data.
    always_comb begin
        host_rdata = '0;
        unique case (host_rd_addr[5:4])
            AREA_CMD: host_rdata[7:0] = host_cmd;
            AREA_TX:  host_rdata[WORD_W-1:0] = host_tx;
            AREA_RX:  host_rdata[WORD_W-1:0] = host_rx;
            default: begin
                unique case (host_rd_addr[3:0])
                    REG_QPTR: begin
                        host_rdata[0 +: IDX_W] = new_qp;
                        host_rdata[4 +: IDX_W] = end_qp;
                    end
                    REG_DIV:  host_rdata[DIV_W-1:0] = div_q;
                    REG_CTRL: host_rdata[1] = irq_en_q;
                    REG_STAT: begin
                        host_rdata[0] = done_f;
                        host_rdata[1] = fault_f;
                        host_rdata[2] = seq_busy;
                        host_rdata[4 +: IDX_W] = cpt_qp;
                    end
                    default: host_rdata = '0;
                endcase
            end
        endcase
    end

    assign irq = done_f && irq_en_q;

    spiq_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .tx_we(tx_we),
        .host_idx(host_addr[IDX_W-1:0]), .host_wdata(host_wdata[WORD_W-1:0]),
        .host_rd_idx(host_rd_addr[IDX_W-1:0]),
        .host_cmd(host_cmd), .host_tx(host_tx), .host_rx(host_rx),
        .eng_idx(eng_idx), .eng_pcs(eng_pcs), .eng_cont(eng_cont),
        .eng_len_full(eng_len_full), .eng_tx(eng_tx),
        .rx_we(rx_we), .rx_wdata(rx_word)
    );

    spiq_shifter #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .start(xfer_start), .abort(abort), .len_full(eng_len_full),
        .tx_word(eng_tx), .div(div_q), .miso(miso),
        .sck(sck), .mosi(mosi), .xfer_done(xfer_done), .rx_word(rx_word)
    );

    spiq_sequencer #(.IDX_W(IDX_W), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .go(go), .abort(abort), .new_qp(new_qp), .end_qp(end_qp), .div(div_q),
        .cmd_pcs(eng_pcs), .cmd_cont(eng_cont), .xfer_done(xfer_done),
        .eng_idx(eng_idx), .xfer_start(xfer_start), .rx_we(rx_we),
        .cpt_qp(cpt_qp), .pcs(pcs), .busy(seq_busy), .queue_done(queue_done)
    );
endmodule

// File: rtl/spiq_checker.sv
// Module: protocol checks for spi_queue_master, attached by bind.
// Assumes it sees the sequencer busy flag, the flags and the receive write strobe.
module spiq_checker #(
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sck,
    input logic             mosi,
    input logic [3:0]       pcs,
    input logic             done_f,
    input logic             irq,
    input logic             irq_en,
    input logic [IDX_W-1:0] cpt_qp,
    input logic             rx_we,
    input logic             ss_n
);
    // Idle controller leaves every chip select at its inactive level.
    assert_pcs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pcs == 4'hF));

    // Idle controller keeps SCK low.
    assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // MOSI holds while SCK is high.
    assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi));

    // Completed-slot pointer moves only after a receive write.
    assert_cpt_after_writeback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpt_qp) |-> $past(rx_we));

    // Done sets exactly when the run ends.
    assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_f) |-> $fell(busy));

    // Interrupt only with done and enable.
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done_f && irq_en));

    // Slave-select low stops a run on the next clock.
    assert_fault_aborts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && busy) |=> !busy);
endmodule

bind spi_queue_master spiq_checker #(.IDX_W(IDX_W)) u_spiq_checker (
    .clk(clk), .rst_n(rst_n), .busy(seq_busy), .sck(sck), .mosi(mosi),
    .pcs(pcs), .done_f(done_f), .irq(irq), .irq_en(irq_en_q),
    .cpt_qp(cpt_qp), .rx_we(rx_we), .ss_n(ss_n)
);

// File: tb/test_spi_queue_master.sv
// Bench: sweeps first/end slot pairs, dividers, lengths and hold bits.
// MISO is the inverse of MOSI, so every expected receive word is computed arithmetically.
module test_spi_queue_master;
    localparam logic [5:0] A_QPTR = 6'h30;
    localparam logic [5:0] A_DIV  = 6'h31;
    localparam logic [5:0] A_CTRL = 6'h32;
    localparam logic [5:0] A_STAT = 6'h33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [5:0]  host_rd_addr = '0;
    logic [15:0] host_rdata;
    logic        sck, mosi, miso, irq;
    logic [3:0]  pcs;
    logic        ss_n = 1'b1;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_rx [16];
    logic        exp_mosi  [512];
    logic [3:0]  exp_pcs   [512];
    logic        exp_first [512];
    int          exp_n;
    int          exp_idle;

    logic        cap_mosi [512];
    logic [3:0]  cap_pcs  [512];
    int          cap_cyc  [512];
    int          cap_n = 0;
    int          idle_cnt = 0;
    int          cyc = 0;
    logic        sck_prev = 1'b0;
    logic [3:0]  pcs_prev = 4'hF;

    always #2 clk = ~clk;
    assign miso = ~mosi;

    spi_queue_master i_spi_queue_master (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rd_addr(host_rd_addr), .host_rdata(host_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .pcs(pcs), .ss_n(ss_n), .irq(irq)
    );

    // Record the bus at each SCK rise and count returns of the chip selects to idle.
    always @(negedge clk) begin
        cyc++;
        if (sck && !sck_prev && cap_n < 512) begin
            cap_mosi[cap_n] = mosi;
            cap_pcs[cap_n]  = pcs;
            cap_cyc[cap_n]  = cyc;
            cap_n++;
        end
        if (pcs == 4'hF && pcs_prev != 4'hF) idle_cnt++;
        sck_prev = sck;
        pcs_prev = pcs;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        @(negedge clk);
        host_rd_addr = a;
        #1 v = host_rdata;
    endtask

    // Load the slots, build the expected stream and start a run.
    task automatic start_queue(input int q, input int s, input int e,
                               input int d, input bit ie);
        exp_n = 0;
        exp_idle = 1;
        for (int i = 0; i < 16; i++) begin
            logic [7:0]  c;
            logic [15:0] t;
            logic        cont, len;
            cont = ((i + q) % 3) == 0;
            len  = ((i + q) % 2) == 1;
            c = {cont, len, 2'b00, 4'((i + q) % 15)};
            t = 16'(i * 16'h01F3 + q * 16'h0A57 + 16'h003C);
            wr(6'(i), {8'h00, c});
            wr(6'(16 + i), t);
            if (i >= s && i <= e) begin
                logic [15:0] w;
                int nb;
                nb = len ? 16 : 8;
                w  = len ? t : {t[7:0], 8'h00};
                for (int b = 0; b < nb; b++) begin
                    exp_mosi[exp_n]  = w[15 - b];
                    exp_pcs[exp_n]   = c[3:0];
                    exp_first[exp_n] = (b == 0);
                    exp_n++;
                end
                m_rx[i] = len ? ~t : {8'h00, ~t[7:0]};
                if (i != e && !cont) exp_idle++;
            end
        end
        wr(A_QPTR, 16'(e * 16 + s));
        wr(A_DIV, 16'(d));
        @(negedge clk);
        cap_n = 0;
        idle_cnt = 0;
        wr(A_CTRL, {14'h0, ie, 1'b1});
    endtask

    // Wait for the run to end, then check stream, slots, pointer, flags and interrupt.
    task automatic finish_and_check(input int e, input int d, input bit ie);
        logic [15:0] v;
        int guard, eff, bad_m, bad_p, bad_t;
        guard = 0;
        v = 16'h0004;
        while (v[2] && guard < 20000) begin
            rd(A_STAT, v);
            guard++;
        end
        chk(guard < 20000, "R8", "run completes", guard, 0);
        eff = (d == 0) ? 1 : d;
        chk(cap_n == exp_n, "R2", "bit count", cap_n, exp_n);
        bad_m = 0; bad_p = 0; bad_t = 0;
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            if (cap_mosi[k] != exp_mosi[k]) bad_m++;
            if (cap_pcs[k] != exp_pcs[k]) bad_p++;
            if (k > 0 && !exp_first[k] && (cap_cyc[k] - cap_cyc[k-1]) != 2 * eff) bad_t++;
        end
        chk(bad_m == 0, "R2", "MOSI bit mismatches", bad_m, 0);
        chk(bad_p == 0, "R5", "chip-select mismatches", bad_p, 0);
        chk(bad_t == 0, "R4", "SCK period mismatches", bad_t, 0);
        chk(idle_cnt == exp_idle, "R6", "returns to idle", idle_cnt, exp_idle);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] r;
            rd(6'(32 + i), r);
            chk(r == m_rx[i], "R3", $sformatf("rx slot %0d", i), r, m_rx[i]);
        end
        rd(A_STAT, v);
        chk(v[7:4] == 4'(e), "R7", "completed pointer", v[7:4], e);
        chk(v[0] == 1'b1 && v[2] == 1'b0, "R8", "done set, busy clear", v[2:0], 1);
        chk(irq == ie, "R9", "irq with done", irq, ie);
        chk(pcs == 4'hF && sck == 1'b0, "R5", "idle outputs", {sck, pcs}, 15);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, v);
        chk(v[0] == 1'b0 && irq == 1'b0, "R8", "done cleared by write 1", {irq, v[0]}, 0);
    endtask

    initial begin
        #(4 * 190000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int q, held;
        for (int i = 0; i < 16; i++) m_rx[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(A_STAT, v);
        chk(v == 16'h0000, "R1", "status after reset", v, 0);
        chk(pcs == 4'hF, "R1", "pcs after reset", pcs, 15);
        chk(sck == 1'b0 && irq == 1'b0, "R1", "sck/irq after reset", {sck, irq}, 0);

        // R2..R9: sweep every first/end pair with first <= end
        q = 0;
        for (int s = 0; s < 16; s++) begin
            for (int e = s; e < 16; e++) begin
                start_queue(q, s, e, q % 4, q[0]);
                finish_and_check(e, q % 4, q[0]);
                q++;
            end
        end

        // R10: a second start written during a run is dropped
        start_queue(q, 2, 5, 2, 1'b0);
        repeat (10) @(negedge clk);
        wr(A_CTRL, 16'h0001);
        finish_and_check(5, 2, 1'b0);
        held = cap_n;
        repeat (200) @(negedge clk);
        rd(A_STAT, v);
        chk(v[2] == 1'b0, "R10", "no restart busy", v[2], 0);
        chk(cap_n == held, "R10", "no extra SCK edges", cap_n, held);
        q++;

        // R11: slave-select low aborts a run and flags a mode fault
        start_queue(q, 0, 15, 3, 1'b1);
        repeat (40) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        ss_n = 1'b1;
        rd(A_STAT, v);
        chk(v[2] == 1'b0, "R11", "busy after fault", v[2], 0);
        chk(v[1] == 1'b1, "R11", "fault flag", v[1], 1);
        chk(v[0] == 1'b0 && irq == 1'b0, "R11", "done stays clear", {irq, v[0]}, 0);
        chk(pcs == 4'hF && sck == 1'b0, "R11", "outputs idle", {sck, pcs}, 15);
        wr(A_STAT, 16'h0002);
        rd(A_STAT, v);
        chk(v[1] == 1'b0, "R11", "fault cleared by write 1", v[1], 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule